// File: doc/BRIEF.md
# GPIO Bank Controller

This block gives software control of a set of general-purpose pins through a simple word-addressed register bus. The pins are split into banks of 32. The number of banks is a parameter, from one to five. Each bank has five live registers:

- a direction register, where a 1 keeps the pin an input and a 0 enables its driver;
- an output latch;
- an atomic set port and an atomic clear port that act on the output latch;
- an input-data register that reads the pin level through a two-stage synchronizer.

Each bank's window is ten words long, at a stride of ten words (0x28 bytes). The first window starts at word 4 (byte 0x10). Window offsets 5 to 9 are reserved for a separate interrupt block. Here they read as zero, and writes to them do nothing. The pins appear as separate output, output-enable and input vectors, so a pad ring or a bench can connect them as needed.

An access is one cycle long: `bus_sel` is high and `bus_we` selects the direction. A write takes effect at the clock edge that samples it. Read data is registered, so it appears after that same edge and holds until the next read.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every direction bit is 1, so `pin_oe` is all zero. The output latch and `pin_out` are zero, and `bus_rdata` is zero.
- R2: Bank b occupies word addresses 4+10b to 13+10b. The word offsets within the bank are: 0 direction, 1 output latch, 2 set, 3 clear, 4 input data. Offsets 5 to 9 read as zero and ignore writes. An access to one bank leaves the other banks unchanged.
- R3: A direction bit of 0 drives `pin_oe` high for that pin, and a 1 drives it low. The change appears one clock after the write. The direction register reads back what was written.
- R4: A write to the output-latch word replaces the latch, and `pin_out` shows the new value one clock later. Without a write to offsets 1 to 3, the latch holds its value.
- R5: A write to the set word turns on the latch bits where the written value has ones. Bits written as zero keep their value.
- R6: A write to the clear word turns off the latch bits where the written value has ones. Bits written as zero keep their value.
- R7: A read of the set word or the clear word returns the current output latch.
- R8: The input-data word returns the synchronized `pin_in` level, also for pins driven as outputs. Suppose a pin changes just before clock edge k. A read sampled at edge k or k+1 returns the old level, and a read sampled at edge k+2 returns the new one.
- R9: A read of a word address outside every bank window returns zero. A write to such an address changes no register.
- R10: `bus_rdata` is loaded only at an edge that samples a read. It holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus, the registers and the synchronizer |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access strobe for one cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_waddr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32*NUM_BANKS | Pin levels from the pads |
| pin_out | output | 32*NUM_BANKS | Output latch driven to the pads |
| pin_oe | output | 32*NUM_BANKS | Output driver enable, high when the direction bit is 0 |

## Verification
The bench builds the block with three banks and a 10-bit word address. This makes the first and middle windows reachable, along with a reserved offset inside a window. It also makes reachable the word just past the last bank (word 34, byte 0x88), which must decode as unmapped. With three banks, the bench can show that a set, clear or direction write lands in one bank only. It can also show that the two-cycle synchronizer delay applies to a bank whose pins are all outputs.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned PINS_PER_BANK  = 32;
  localparam int unsigned BANK_BASE_WORD = 4;   // byte 0x10
  localparam int unsigned BANK_WORDS     = 10;  // byte stride 0x28
  localparam int unsigned SEL_W          = 4;

  // Word offset inside a bank window; offsets 5..9 are reserved.
  typedef enum logic [SEL_W-1:0] {
    REG_DIR  = 4'd0,
    REG_DOUT = 4'd1,
    REG_DSET = 4'd2,
    REG_DCLR = 4'd3,
    REG_DIN  = 4'd4
  } gpio_reg_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned ADDR_W    = 10
) (
  input  logic [ADDR_W-1:0]    waddr,
  output logic [NUM_BANKS-1:0] bank_hit,
  output logic [SEL_W-1:0]     reg_sel
);

  logic [31:0]      word32;
  logic [SEL_W-1:0] offs [NUM_BANKS];

  assign word32 = 32'(waddr);

  // One window comparator per bank; no divider in the decode path.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_win
    localparam int unsigned BASE = BANK_BASE_WORD + BANK_WORDS * b;
    assign bank_hit[b] = (word32 >= 32'(BASE)) && (word32 < 32'(BASE + BANK_WORDS));
    assign offs[b]     = SEL_W'(word32 - 32'(BASE));
  end

  always_comb begin
    reg_sel = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) reg_sel = reg_sel | offs[b];
    end
  end

  // R2: windows never overlap
  always_comb begin
    p_single_window_r2: assert ($onehot0(bank_hit));
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         reg_sel,
  input  logic [31:0]              wdata,
  input  logic [PINS_PER_BANK-1:0] pin_in,
  output logic [PINS_PER_BANK-1:0] dir,
  output logic [PINS_PER_BANK-1:0] dout,
  output logic [31:0]              rd_val
);

  logic [PINS_PER_BANK-1:0] dir_q, dir_d;
  logic [PINS_PER_BANK-1:0] out_q, out_d;
  logic [PINS_PER_BANK-1:0] sync1_q, sync2_q;
  logic                     dir_en, out_en;

  // Next state and clock enables
  always_comb begin
    dir_en = wr_en && (reg_sel == REG_DIR);
    out_en = wr_en && ((reg_sel == REG_DOUT) || (reg_sel == REG_DSET) ||
                       (reg_sel == REG_DCLR));
    dir_d  = wdata;
    case (reg_sel)
      REG_DSET: out_d = out_q | wdata;
      REG_DCLR: out_d = out_q & ~wdata;
      default:  out_d = wdata;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      out_q <= '0;
    end else begin
      if (dir_en) dir_q <= dir_d;
      if (out_en) out_q <= out_d;
    end
  end

  // Two-stage input synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    case (reg_sel)
      REG_DIR:                     rd_val = dir_q;
      REG_DOUT, REG_DSET, REG_DCLR: rd_val = out_q;
      REG_DIN:                     rd_val = sync2_q;
      default:                     rd_val = '0;
    endcase
  end

  assign dir  = dir_q;
  assign dout = out_q;

  // Counts edges since reset so the synchronizer check never looks into reset
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                warm_q <= 2'd0;
    else if (warm_q != 2'd2)   warm_q <= warm_q + 2'd1;
  end

  p_dir_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == REG_DIR) |=> (dir == $past(wdata)));

  p_latch_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == REG_DOUT) |=> (dout == $past(wdata)));

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (reg_sel == REG_DOUT || reg_sel == REG_DSET || reg_sel == REG_DCLR))
    |=> $stable(dout));

  p_set_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == REG_DSET) |=>
    (dout == ($past(dout) | $past(wdata))));

  p_clr_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == REG_DCLR) |=>
    (dout == ($past(dout) & ~$past(wdata))));

  p_reserved_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel > REG_DIN) |=> ($stable(dout) && $stable(dir)));

  p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (sync2_q == $past(pin_in, 2)));

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned ADDR_W    = 10
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_sel,
  input  logic                              bus_we,
  input  logic [ADDR_W-1:0]                 bus_waddr,
  input  logic [31:0]                       bus_wdata,
  output logic [31:0]                       bus_rdata,
  input  logic [PINS_PER_BANK*NUM_BANKS-1:0] pin_in,
  output logic [PINS_PER_BANK*NUM_BANKS-1:0] pin_out,
  output logic [PINS_PER_BANK*NUM_BANKS-1:0] pin_oe
);

  logic                   rst_n_q;
  logic [NUM_BANKS-1:0]   bank_hit;
  logic [SEL_W-1:0]       reg_sel;
  logic [31:0]            bank_rd [NUM_BANKS];
  logic [31:0]            rd_mux;
  logic [31:0]            rdata_q;
  logic                   rd_en;

  gpio_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_q)
  );

  gpio_addr_dec #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
  ) i_dec (
    .waddr    (bus_waddr),
    .bank_hit (bank_hit),
    .reg_sel  (reg_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [PINS_PER_BANK-1:0] dir_b;
    gpio_bank i_bank (
      .clk     (clk),
      .rst_n   (rst_n_q),
      .wr_en   (bus_sel && bus_we && bank_hit[b]),
      .reg_sel (reg_sel),
      .wdata   (bus_wdata),
      .pin_in  (pin_in[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .dir     (dir_b),
      .dout    (pin_out[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .rd_val  (bank_rd[b])
    );
    assign pin_oe[b*PINS_PER_BANK +: PINS_PER_BANK] = ~dir_b;
  end

  // Read select and read-data register
  always_comb begin
    rd_en  = bus_sel && !bus_we;
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) rd_mux = rd_mux | bank_rd[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q)   rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n_q)
    (rd_en && bank_hit == '0) |=> (bus_rdata == '0));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n_q)
    !rd_en |=> $stable(bus_rdata));

endmodule

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;

  localparam int unsigned NB   = 3;
  localparam int unsigned AW   = 10;
  localparam int unsigned NPIN = 32 * NB;
  localparam int unsigned NVEC = 27;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_sel, bus_we;
  logic [AW-1:0]   bus_waddr;
  logic [31:0]     bus_wdata, bus_rdata;
  logic [NPIN-1:0] pin_in, pin_out, pin_oe;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) i_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {req[3:0], we, waddr[9:0], wdata[31:0], expected[31:0]}
  localparam logic [78:0] VEC [NVEC] = '{
    {4'd1, 1'b0, 10'd4,  32'h0,        32'hFFFFFFFF}, // R1 dir reset
    {4'd1, 1'b0, 10'd5,  32'h0,        32'h00000000}, // R1 latch reset
    {4'd4, 1'b1, 10'd5,  32'hA5A50F0F, 32'h0},        // R4 load
    {4'd4, 1'b0, 10'd5,  32'h0,        32'hA5A50F0F}, // R4
    {4'd5, 1'b1, 10'd6,  32'h0000F0F0, 32'h0},        // R5 set
    {4'd7, 1'b0, 10'd7,  32'h0,        32'hA5A5FFFF}, // R7 read clear word
    {4'd6, 1'b1, 10'd7,  32'hA500000F, 32'h0},        // R6 clear
    {4'd7, 1'b0, 10'd6,  32'h0,        32'h00A5FFF0}, // R7 read set word
    {4'd4, 1'b1, 10'd15, 32'h12345678, 32'h0},        // R4 bank1
    {4'd4, 1'b0, 10'd15, 32'h0,        32'h12345678}, // R4
    {4'd2, 1'b0, 10'd5,  32'h0,        32'h00A5FFF0}, // R2 bank0 untouched
    {4'd3, 1'b1, 10'd24, 32'h0000FFFF, 32'h0},        // R3 bank2 dir
    {4'd3, 1'b0, 10'd24, 32'h0,        32'h0000FFFF}, // R3
    {4'd2, 1'b1, 10'd9,  32'hFFFFFFFF, 32'h0},        // R2 reserved write
    {4'd2, 1'b0, 10'd9,  32'h0,        32'h00000000}, // R2 reserved read
    {4'd2, 1'b0, 10'd5,  32'h0,        32'h00A5FFF0}, // R2 latch untouched
    {4'd9, 1'b1, 10'd34, 32'hFFFFFFFF, 32'h0},        // R9 past last bank
    {4'd9, 1'b0, 10'd34, 32'h0,        32'h00000000}, // R9
    {4'd9, 1'b0, 10'd3,  32'h0,        32'h00000000}, // R9 below first bank
    {4'd9, 1'b1, 10'd3,  32'hFFFFFFFF, 32'h0},        // R9
    {4'd9, 1'b0, 10'd4,  32'h0,        32'hFFFFFFFF}, // R9 dir untouched
    {4'd3, 1'b1, 10'd14, 32'h00000000, 32'h0},        // R3 bank1 all outputs
    {4'd3, 1'b0, 10'd14, 32'h0,        32'h00000000}, // R3
    {4'd5, 1'b1, 10'd16, 32'h00000000, 32'h0},        // R5 set with zeros
    {4'd5, 1'b0, 10'd15, 32'h0,        32'h12345678}, // R5 no change
    {4'd6, 1'b1, 10'd17, 32'hFFFF0000, 32'h0},        // R6 clear upper
    {4'd6, 1'b0, 10'd15, 32'h0,        32'h00005678}  // R6
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Both tasks start and end at a falling edge.
  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_waddr = a; bus_wdata = '0;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd, hold;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_waddr = '0; bus_wdata = '0;
    pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state at the ports
    for (int b = 0; b < NB; b++) begin
      check(1, pin_oe[b*32 +: 32], 32'h0, "pin_oe after reset");
      check(1, pin_out[b*32 +: 32], 32'h0, "pin_out after reset");
    end
    check(1, bus_rdata, 32'h0, "rdata after reset");

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][74]) bus_write(VEC[i][73:64], VEC[i][63:32]);
      else begin
        bus_read(VEC[i][73:64], rd);
        check(int'(VEC[i][78:75]), rd, VEC[i][31:0], $sformatf("vector %0d", i));
      end
    end

    // R3 / R4 pins per bank
    check(3, pin_oe[31:0],  32'h00000000, "bank0 oe");
    check(3, pin_oe[63:32], 32'hFFFFFFFF, "bank1 oe");
    check(3, pin_oe[95:64], 32'hFFFF0000, "bank2 oe");
    check(4, pin_out[31:0],  32'h00A5FFF0, "bank0 out");
    check(4, pin_out[63:32], 32'h00005678, "bank1 out");
    check(4, pin_out[95:64], 32'h00000000, "bank2 out");

    // R8: bank1 pins are outputs; pin level change seen two edges later
    pin_in[63:32] = 32'hCAFEF00D;
    bus_read(10'd18, rd); check(8, rd, 32'h0, "in-data at edge k");
    bus_read(10'd18, rd); check(8, rd, 32'h0, "in-data at edge k+1");
    bus_read(10'd18, rd); check(8, rd, 32'hCAFEF00D, "in-data at edge k+2");
    bus_read(10'd8, rd);  check(8, rd, 32'h0, "bank0 in-data unaffected");

    // R10: rdata holds across idle and write cycles
    bus_read(10'd15, rd);
    hold = bus_rdata;
    @(negedge clk);
    check(10, bus_rdata, hold, "rdata idle hold");
    bus_write(10'd25, 32'h0F0F0F0F);
    check(10, bus_rdata, hold, "rdata hold over write");
    check(4, pin_out[95:64], 32'h0F0F0F0F, "bank2 out after load");

    // R1 again: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    check(1, pin_oe[63:32], 32'h0, "oe during reset");
    check(1, pin_out[31:0], 32'h0, "out during reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(10'd14, rd); check(1, rd, 32'hFFFFFFFF, "bank1 dir after reset");

    summary();
    $finish;
  end

endmodule